// File: doc/BRIEF.md
# Phase-Shedding Reference Ramp Sequencer

This block sets the current reference for the one phase of a two-phase interleaved buck regulator that can be switched off. If that phase were cut off at once, its current would fall much faster than the other phase can pick it up, and the output voltage would sag. This sequencer avoids that. When the phase is told to switch off, its reference falls gradually along a ramp until the sensed phase current is near zero, and the reference is then held at zero. When the phase is told to switch back on, the reference climbs from its present level until the phase current reaches about half of the shared reference, and from then on it follows the shared reference.

A four-state machine runs the sequence. A saturating accumulator adds one programmable step per clock, which sets the slope. For a 1 MHz tick and a 0.01 A current LSB, a step of 60 gives 6×10^5 A/s and a step of 6 gives a slope ten times slower. All currents are 16-bit signed values on one scale. Both outputs are registered.

Top module: `phase_shed_ramp`

## Requirements
- R1: While `rst` is high, the next clock edge sets `state_code` to 00 and `ref_out` to 0.
- R2: The state code is {reference-select, ramp-select}: 10 follow, 11 ramp down, 00 off, 01 ramp up. While the code is 10 and `phase_en` is 1, each edge loads `ref_out` with the `i_ref_shared` value present at that edge.
- R3: In state 10 or 01, `phase_en` = 0 moves the machine to 11 at the next edge, whatever the phase current is.
- R4: On the edge that enters 11 from 10, `ref_out` equals `i_ref_shared`. On each later edge in 11 it equals `i_ref_shared` minus k·`ramp_step`, where k is the number of edges spent in 11 since entry.
- R5: In state 11, if |`i_phase`| <= ZERO_THR and `phase_en` stays 0, the machine moves to 00. While in 00, `ref_out` is 0.
- R6: In state 00 or 11, `phase_en` = 1 moves the machine to 01 at the next edge.
- R7: On the edge that enters 01 from 00, `ref_out` is 0. On each later edge in 01 it rises by `ramp_step`.
- R8: In state 01 with `phase_en` = 1, if `i_phase` >= (`i_ref_shared` >>> 1) − `avg_tol`, the machine moves to 10 and `ref_out` takes `i_ref_shared`.
- R9: `ref_out` saturates to the range 0 … 32767. It never goes negative and never wraps.
- R10: When the direction reverses in the middle of a ramp (11→01 or 01→11), `ref_out` keeps its value on the reversing edge, and the new ramp continues from that value.
- R11: The enable command takes priority over the detectors. In 11, `phase_en` = 1 wins over a zero-current detect. In 01, `phase_en` = 0 wins over an average-current detect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control tick clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_en | input | 1 | 1 = phase wanted on, 0 = shed it |
| i_phase | input | 16 | Signed sampled phase current |
| i_ref_shared | input | 16 | Signed shared reference from the compensator |
| ramp_step | input | 16 | Unsigned ramp increment per clock |
| avg_tol | input | 16 | Unsigned tolerance below half of the shared reference |
| ref_out | output | 16 | Signed phase reference current, registered |
| state_code | output | 2 | {reference-select, ramp-select} state |

## Verification
The hardest case to reach from the ports is a reversal of the enable command in the middle of a ramp, on the same cycle that the opposite detector would also fire. Examples are an enable rise while the phase current is already inside the zero band, or a drop while the current is already above the average threshold. Directed sequences hold the current at those detector values exactly at the reversal. The run then checks that the reference keeps its level through the reversal and ramps on from it. A long random phase toggles the enable rarely, and it mixes near-zero, near-average and arbitrary currents so that reversals land at many ramp depths.

// File: rtl/phs_pkg.sv
package phs_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'b00,
    ST_UP     = 2'b01,
    ST_FOLLOW = 2'b10,
    ST_DOWN   = 2'b11
  } phs_state_t;

  typedef enum logic [2:0] {
    ACT_OFF,
    ACT_TRACK,
    ACT_DN_START,
    ACT_DN_STEP,
    ACT_DN_TURN,
    ACT_UP_START,
    ACT_UP_STEP,
    ACT_UP_TURN
  } phs_act_t;
endpackage

// File: rtl/phs_detect.sv
module phs_detect #(
  parameter int W        = 16,
  parameter int ZERO_THR = 4
) (
  input  logic signed [W-1:0] i_phase,
  input  logic signed [W-1:0] i_ref_shared,
  input  logic        [W-1:0] avg_tol,
  output logic                nonzero,
  output logic                avg_hit
);
  localparam int XW = W + 2;

  logic signed [XW-1:0] ph_x, mag, sh_x, half, tol_x, thr;

  always_comb begin
    ph_x  = XW'(i_phase);
    sh_x  = XW'(i_ref_shared);
    tol_x = $signed({2'b00, avg_tol});
    mag   = (ph_x < 0) ? -ph_x : ph_x;
    half  = sh_x >>> 1;
    thr   = half - tol_x;
    nonzero = (mag > XW'(ZERO_THR));
    avg_hit = (ph_x >= thr);
  end
endmodule

// File: rtl/phs_fsm.sv
module phs_fsm
  import phs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       phase_en,
  input  logic       nonzero,
  input  logic       avg_hit,
  output phs_state_t state_q,
  output phs_act_t   act
);
  phs_state_t nxt;

  always_comb begin
    nxt = state_q;
    act = ACT_OFF;
    unique case (state_q)
      ST_FOLLOW: begin
        if (!phase_en) begin
          nxt = ST_DOWN;
          act = ACT_DN_START;
        end else begin
          act = ACT_TRACK;
        end
      end
      ST_DOWN: begin
        if (phase_en) begin
          nxt = ST_UP;
          act = ACT_UP_TURN;
        end else if (!nonzero) begin
          nxt = ST_OFF;
          act = ACT_OFF;
        end else begin
          act = ACT_DN_STEP;
        end
      end
      ST_OFF: begin
        if (phase_en) begin
          nxt = ST_UP;
          act = ACT_UP_START;
        end else begin
          act = ACT_OFF;
        end
      end
      ST_UP: begin
        if (!phase_en) begin
          nxt = ST_DOWN;
          act = ACT_DN_TURN;
        end else if (avg_hit) begin
          nxt = ST_FOLLOW;
          act = ACT_TRACK;
        end else begin
          act = ACT_UP_STEP;
        end
      end
      default: begin
        nxt = ST_OFF;
        act = ACT_OFF;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OFF;
    else     state_q <= nxt;
  end
endmodule

// File: rtl/phs_ramp.sv
module phs_ramp
  import phs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  phs_act_t            act,
  input  logic signed [W-1:0] i_ref_shared,
  input  logic        [W-1:0] ramp_step,
  output logic signed [W-1:0] ref_q
);
  localparam int AW = W + 2;
  localparam logic signed [AW-1:0] ACC_MAX = $signed({2'b00, {W{1'b1}}});
  localparam logic signed [AW-1:0] REF_MAX = $signed({3'b000, {(W-1){1'b1}}});

  logic signed [AW-1:0] acc_q, acc_d, acc_sum, acc_inc;
  logic signed [AW-1:0] sh_x, step_x, ref_x, ref_raw;
  logic signed [W-1:0]  ref_d;

  always_comb begin
    sh_x    = AW'(i_ref_shared);
    step_x  = $signed({2'b00, ramp_step});
    ref_x   = AW'(ref_q);
    acc_sum = acc_q + step_x;
    acc_inc = (acc_sum > ACC_MAX) ? ACC_MAX : acc_sum;
    acc_d   = acc_q;
    ref_raw = '0;
    unique case (act)
      ACT_TRACK:    begin acc_d = '0;          ref_raw = sh_x;           end
      ACT_DN_START: begin acc_d = '0;          ref_raw = sh_x;           end
      ACT_DN_STEP:  begin acc_d = acc_inc;     ref_raw = sh_x - acc_inc; end
      ACT_DN_TURN:  begin acc_d = sh_x - ref_x; ref_raw = ref_x;         end
      ACT_UP_START: begin acc_d = '0;          ref_raw = '0;             end
      ACT_UP_STEP:  begin acc_d = acc_inc;     ref_raw = acc_inc;        end
      ACT_UP_TURN:  begin acc_d = ref_x;       ref_raw = ref_x;          end
      default:      begin acc_d = '0;          ref_raw = '0;             end
    endcase
    if (ref_raw < 0)            ref_d = '0;
    else if (ref_raw > REF_MAX) ref_d = REF_MAX[W-1:0];
    else                        ref_d = ref_raw[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ref_q <= '0;
    end else begin
      acc_q <= acc_d;
      ref_q <= ref_d;
    end
  end
endmodule

// File: rtl/phase_shed_ramp.sv
module phase_shed_ramp
  import phs_pkg::*;
#(
  parameter int W        = 16,
  parameter int ZERO_THR = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                phase_en,
  input  logic signed [W-1:0] i_phase,
  input  logic signed [W-1:0] i_ref_shared,
  input  logic        [W-1:0] ramp_step,
  input  logic        [W-1:0] avg_tol,
  output logic signed [W-1:0] ref_out,
  output logic        [1:0]   state_code
);
  logic       nonzero, avg_hit;
  phs_state_t state_q;
  phs_act_t   act;

  phs_detect #(.W(W), .ZERO_THR(ZERO_THR)) u_detect (
    .i_phase      (i_phase),
    .i_ref_shared (i_ref_shared),
    .avg_tol      (avg_tol),
    .nonzero      (nonzero),
    .avg_hit      (avg_hit)
  );

  phs_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .phase_en (phase_en),
    .nonzero  (nonzero),
    .avg_hit  (avg_hit),
    .state_q  (state_q),
    .act      (act)
  );

  phs_ramp #(.W(W)) u_ramp (
    .clk          (clk),
    .rst          (rst),
    .act          (act),
    .i_ref_shared (i_ref_shared),
    .ramp_step    (ramp_step),
    .ref_q        (ref_out)
  );

  assign state_code = state_q;
endmodule

// File: rtl/phase_shed_ramp_chk.sv
module phase_shed_ramp_chk #(
  parameter int W        = 16,
  parameter int ZERO_THR = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                phase_en,
  input logic signed [W-1:0] i_phase,
  input logic signed [W-1:0] i_ref_shared,
  input logic        [W-1:0] avg_tol,
  input logic signed [W-1:0] ref_out,
  input logic        [1:0]   state_code
);
  logic signed [W+1:0] avg_thr;
  assign avg_thr = (($signed({i_ref_shared[W-1], i_ref_shared[W-1], i_ref_shared})) >>> 1)
                   - $signed({2'b00, avg_tol});

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (state_code == 2'b00 && ref_out == '0));

  assert_follow_tracks_R2: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b10 && phase_en) |=> (ref_out == $past(i_ref_shared) || $past(i_ref_shared) < 0));

  assert_shed_start_R3: assert property (@(posedge clk) disable iff (rst)
    ((state_code == 2'b10 || state_code == 2'b01) && !phase_en) |=> state_code == 2'b11);

  assert_off_holds_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b00) |-> ref_out == '0);

  assert_restore_start_R6: assert property (@(posedge clk) disable iff (rst)
    ((state_code == 2'b00 || state_code == 2'b11) && phase_en) |=> state_code == 2'b01);

  assert_avg_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b01 && phase_en && $signed({i_phase[W-1], i_phase[W-1], i_phase}) >= avg_thr)
    |=> state_code == 2'b10);

  assert_no_negative_R9: assert property (@(posedge clk) disable iff (rst)
    ref_out >= 0);

  assert_turn_hold_R10: assert property (@(posedge clk) disable iff (rst)
    ((state_code == 2'b11 && phase_en) || (state_code == 2'b01 && !phase_en))
    |=> ref_out == $past(ref_out));
endmodule

bind phase_shed_ramp phase_shed_ramp_chk #(.W(W), .ZERO_THR(ZERO_THR)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .phase_en     (phase_en),
  .i_phase      (i_phase),
  .i_ref_shared (i_ref_shared),
  .avg_tol      (avg_tol),
  .ref_out      (ref_out),
  .state_code   (state_code)
);

// File: tb/phase_shed_ramp_tb.sv
`timescale 1ns/1ps
module phase_shed_ramp_tb;
  localparam int W = 16;
  localparam int ZTHR = 4;
  localparam int ACCMAX = 65535;
  localparam int REFMAX = 32767;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase_en = 1'b0;
  logic signed [W-1:0] i_phase = '0;
  logic signed [W-1:0] i_ref_shared = '0;
  logic [W-1:0] ramp_step = '0;
  logic [W-1:0] avg_tol = '0;
  logic signed [W-1:0] ref_out;
  logic [1:0] state_code;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_state = 0;
  int m_acc = 0;
  int m_ref = 0;

  always #2 clk = ~clk;

  phase_shed_ramp #(.W(W), .ZERO_THR(ZTHR)) u_dut (
    .clk(clk), .rst(rst), .phase_en(phase_en), .i_phase(i_phase),
    .i_ref_shared(i_ref_shared), .ramp_step(ramp_step), .avg_tol(avg_tol),
    .ref_out(ref_out), .state_code(state_code)
  );

  function automatic int clampr(int v);
    if (v < 0) return 0;
    if (v > REFMAX) return REFMAX;
    return v;
  endfunction

  function automatic int clampa(int v);
    return (v > ACCMAX) ? ACCMAX : v;
  endfunction

  // Next-state model taken from the requirements (state codes as in R2).
  task automatic model_step();
    int ip, sh, st, tl, mag, half;
    bit y, z;
    ip = int'(i_phase); sh = int'(i_ref_shared);
    st = int'(ramp_step); tl = int'(avg_tol);
    mag = (ip < 0) ? -ip : ip;
    half = (sh >= 0) ? sh / 2 : -((-sh + 1) / 2);
    y = mag > ZTHR;
    z = ip >= half - tl;
    if (rst) begin
      m_state = 0; m_acc = 0; m_ref = 0;
      return;
    end
    case (m_state)
      2: if (!phase_en) begin m_state = 3; m_acc = 0; m_ref = clampr(sh); end
         else m_ref = clampr(sh);
      3: if (phase_en) begin m_state = 1; m_acc = m_ref; end
         else if (!y) begin m_state = 0; m_acc = 0; m_ref = 0; end
         else begin m_acc = clampa(m_acc + st); m_ref = clampr(sh - m_acc); end
      0: if (phase_en) begin m_state = 1; m_acc = 0; m_ref = 0; end
         else begin m_acc = 0; m_ref = 0; end
      default:
         if (!phase_en) begin m_state = 3; m_acc = sh - m_ref; end
         else if (z) begin m_state = 2; m_acc = 0; m_ref = clampr(sh); end
         else begin m_acc = clampa(m_acc + st); m_ref = clampr(m_acc); end
    endcase
  endtask

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    #1;
    chk({tag, " state"}, int'(state_code), m_state);
    chk({tag, " ref"}, int'(ref_out), m_ref);
    @(negedge clk);
  endtask

  task automatic drive(bit en, int ip, int sh);
    phase_en = en;
    i_phase = W'(ip);
    i_ref_shared = W'(sh);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) cyc("R1");
    chk("R1 reset state", int'(state_code), 0);
    chk("R1 reset ref", int'(ref_out), 0);
    rst = 1'b0;

    ramp_step = 16'd60; avg_tol = 16'd0;
    drive(1'b0, 0, 1000); cyc("R5");
    drive(1'b1, 0, 1000); cyc("R6");
    chk("R6 up state", int'(state_code), 1);
    cyc("R7"); cyc("R7"); cyc("R7");
    chk("R7 ramp level", int'(ref_out), 180);
    drive(1'b1, 490, 1000); cyc("R8");
    chk("R8 below avg stays", int'(state_code), 1);
    drive(1'b1, 500, 1000); cyc("R8");
    chk("R8 follow entry", int'(state_code), 2);
    chk("R8 ref to shared", int'(ref_out), 1000);
    drive(1'b1, 700, 1200); cyc("R2");
    chk("R2 follow ref", int'(ref_out), 1200);
    drive(1'b0, 800, 1200); cyc("R3");
    chk("R3 down state", int'(state_code), 3);
    chk("R4 entry ref", int'(ref_out), 1200);
    cyc("R4"); cyc("R4");
    chk("R4 ramp down", int'(ref_out), 1080);
    drive(1'b1, 0, 1200); cyc("R11");
    chk("R11 enable beats zero", int'(state_code), 1);
    chk("R10 hold on turn", int'(ref_out), 1080);
    drive(1'b1, 100, 1200); cyc("R10");
    chk("R10 continue up", int'(ref_out), 1140);
    drive(1'b0, 600, 1200); cyc("R11");
    chk("R11 disable beats avg", int'(state_code), 3);
    chk("R10 hold on turn down", int'(ref_out), 1140);
    drive(1'b0, 600, 1200); cyc("R10");
    chk("R10 continue down", int'(ref_out), 1080);
    drive(1'b0, -3, 1200); cyc("R5");
    chk("R5 off state", int'(state_code), 0);
    chk("R5 off ref", int'(ref_out), 0);

    drive(1'b1, 0, 100); cyc("R9");
    drive(1'b1, 50, 100); cyc("R9");
    drive(1'b0, 200, 100); cyc("R9");
    cyc("R9"); cyc("R9");
    chk("R9 floor at zero", int'(ref_out), 0);
    cyc("R9");
    chk("R9 still zero", int'(ref_out), 0);
    drive(1'b1, -200, 30000); cyc("R9");
    ramp_step = 16'hFFFF;
    cyc("R9"); cyc("R9");
    chk("R9 ceiling", int'(ref_out), REFMAX);
    ramp_step = 16'd60;
    drive(1'b0, 0, 30000); cyc("R3");
    cyc("R5");

    for (int i = 0; i < 4000; i++) begin
      int r, sh, ip;
      if (($urandom % 40) == 0) phase_en = ~phase_en;
      if (($urandom % 25) == 0) ramp_step = W'($urandom % 400);
      if (($urandom % 25) == 0) avg_tol = W'($urandom % 60);
      sh = ($urandom % 10) == 0 ? -int'($urandom % 500) : int'($urandom % 20000);
      r = $urandom % 4;
      case (r)
        0: ip = int'($urandom % 9) - 4;
        1: ip = sh / 2 + int'($urandom % 41) - 20;
        default: ip = int'($urandom % 30000) - 5000;
      endcase
      drive(phase_en, ip, sh);
      cyc("R4 R7 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule